// File: doc/BRIEF.md
# Legacy Peripheral Configuration Register and Port Decoder

This block is the configuration front end of a legacy PC multi-function peripheral device on an ISA-style I/O bus. It holds one 8-bit configuration byte at I/O port 3F3h. It turns every bus address into a chip select for one of the device's functions: floppy controller, parallel port, two serial UARTs, an IDE channel, or the configuration register itself.

The configuration byte chooses which functions are present and where they sit. The floppy controller can be switched on or off at its primary range. The parallel port takes one of three bases or is off. The two serial ports follow one of several mappings, including swapped and alternate-base layouts. The IDE channel can be switched on if the build includes it. The block also reports which interrupt line each serial port should drive. That choice comes from the base the port was given. It also reports whether the parallel interrupt is in use.

The chip selects are pure combinational decode of the address and the stored byte. No strobe gates them. A write to 3F3h is stored on the clock edge that ends the write cycle.

Top module: `sio_cfg_decode`

## Requirements
- R1: When `io_wr` is high and `io_addr` is 3F3h at a rising clock edge, the stored byte becomes `io_wdata`. While `io_rd` is high at 3F3h, `cfg_rdata` shows the whole stored byte. Otherwise `cfg_rdata` is 00h and the stored byte keeps its value.
- R2: After reset the stored byte is 9Dh. With that value the floppy range is on, the parallel port is at 378h, serial A is at 3F8h, serial B is at 2F8h, and IDE is off.
- R3: When byte bit 0 is 1, `cs_fdc` is high for 3F0h–3F7h. Two addresses are left out: 3F3h always, and 3F6h while IDE is on. When bit 0 is 0, `cs_fdc` is never high.
- R4: Byte bits 2:1 place the parallel port as follows:
  - 00: off.
  - 01: 3BCh–3BFh (4 ports).
  - 10: 378h–37Fh (8 ports).
  - 11: 278h–27Fh (8 ports).
  
  `lpt_irq_en` is 1 exactly when the port is not off.
- R5: Byte bits 5:3 select the serial layout. Each port covers 8 ports from its base:
  - 001: A at 3F8h only.
  - 010: B at 2F8h only.
  - 011: A at 3F8h, B at 2F8h.
  - 100: A at 3E8h, B at 2E8h.
  - 110: B at 3F8h only.
  - 111: A at 2F8h, B at 3F8h.
  - 000 and 101: both ports off.
- R6: `uart_a_irq4` / `uart_b_irq4` is 1 when that port is on and address bit 8 of its base is 1 (IRQ4). It is 0 otherwise (IRQ3, or the port is off).
- R7: With parameter `HAS_IDE`=1 and byte bit 6 set, `cs_ide` is high for 1F0h–1F7h and for 3F6h. With `HAS_IDE`=0, or with bit 6 clear, `cs_ide` is never high.
- R8: `cs_cfg` is high exactly when `io_addr` is 3F3h, whatever the stored byte.
- R9: For every stored byte and every address, at most one of `cs_cfg`, `cs_fdc`, `cs_lpt`, `cs_uart_a`, `cs_uart_b`, `cs_ide` is high.
- R10: Byte bit 7 is stored and read back but changes no chip select or interrupt output.
- R11: A stored write is seen on the decode and readback outputs straight after the clock edge that stores it, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| cfg_rdata | output | 8 | Configuration byte readback, 00h when not read |
| cs_cfg | output | 1 | Configuration register select |
| cs_fdc | output | 1 | Floppy controller select |
| cs_lpt | output | 1 | Parallel port select |
| cs_uart_a | output | 1 | Serial port A select |
| cs_uart_b | output | 1 | Serial port B select |
| cs_ide | output | 1 | IDE channel select (command block or control port) |
| lpt_irq_en | output | 1 | Parallel port interrupt in use |
| uart_a_irq4 | output | 1 | Serial A routed to IRQ4 (0 means IRQ3 or off) |
| uart_b_irq4 | output | 1 | Serial B routed to IRQ4 (0 means IRQ3 or off) |

## Verification
All chip selects and interrupt outputs follow the address and the stored byte with no register in between. The bench therefore checks them one time step after each address change, with no clock edge in between.

A configuration write is the only timed event. Its result is due one edge later. The bench checks readback while the write is still pending and expects the old byte. It checks again just after the storing edge and expects the new byte. It then probes decode boundaries for all 256 byte values and for random bytes and addresses.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int IO_AW  = 16;
  localparam int CFG_W  = 8;

  localparam logic [IO_AW-1:0] CFG_PORT  = 16'h03F3;
  localparam logic [IO_AW-1:0] FDC_BASE  = 16'h03F0;
  localparam logic [IO_AW-1:0] IDE_CMD   = 16'h01F0;
  localparam logic [IO_AW-1:0] IDE_CTL   = 16'h03F6;
  localparam logic [IO_AW-1:0] LPT_MONO  = 16'h03BC;
  localparam logic [IO_AW-1:0] LPT_PRI   = 16'h0378;
  localparam logic [IO_AW-1:0] LPT_SEC   = 16'h0278;
  localparam logic [IO_AW-1:0] COM_P1    = 16'h03F8;
  localparam logic [IO_AW-1:0] COM_P2    = 16'h02F8;
  localparam logic [IO_AW-1:0] COM_P3    = 16'h03E8;
  localparam logic [IO_AW-1:0] COM_P4    = 16'h02E8;

  localparam logic [IO_AW-1:0] MASK8 = 16'hFFF8;
  localparam logic [IO_AW-1:0] MASK4 = 16'hFFFC;
  localparam logic [IO_AW-1:0] MASK1 = 16'hFFFF;

  // window indices
  localparam int W_FDC  = 0;
  localparam int W_LPT  = 1;
  localparam int W_UA   = 2;
  localparam int W_UB   = 3;
  localparam int W_IDEC = 4;
  localparam int W_IDEK = 5;
  localparam int NWIN   = 6;

  typedef struct packed {
    logic             en;
    logic [IO_AW-1:0] base;
  } io_win_t;

  typedef struct packed {
    io_win_t a;
    io_win_t b;
  } uart_map_t;

  function automatic uart_map_t uart_layout(input logic [2:0] sel);
    uart_map_t m;
    m = '0;
    unique case (sel)
      3'b001: m.a = '{1'b1, COM_P1};
      3'b010: m.b = '{1'b1, COM_P2};
      3'b011: begin m.a = '{1'b1, COM_P1}; m.b = '{1'b1, COM_P2}; end
      3'b100: begin m.a = '{1'b1, COM_P3}; m.b = '{1'b1, COM_P4}; end
      3'b110: m.b = '{1'b1, COM_P1};
      3'b111: begin m.a = '{1'b1, COM_P2}; m.b = '{1'b1, COM_P1}; end
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/sio_cfg_reg.sv
module sio_cfg_reg
  import sio_cfg_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_VAL = 8'h9D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic             rst_sync_n
);
  logic [1:0]       sync_q;
  logic [CFG_W-1:0] cfg_d;

  // reset: asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cfg_q <= RST_VAL;
    else             cfg_q <= cfg_d;
  end
endmodule

// File: rtl/sio_win_match.sv
module sio_win_match #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  input  logic          en,
  output logic          hit
);
  assign hit = en && (((addr ^ base) & mask) == '0);
endmodule

// File: rtl/sio_port_map.sv
module sio_port_map
  import sio_cfg_pkg::*;
#(
  parameter bit HAS_IDE = 1'b1
) (
  input  logic [CFG_W-1:0] cfg,
  output logic [IO_AW-1:0] win_base [NWIN],
  output logic [IO_AW-1:0] win_mask [NWIN],
  output logic             win_en   [NWIN],
  output logic             lpt_irq_en,
  output logic             ua_irq4,
  output logic             ub_irq4
);
  uart_map_t umap;
  logic      ide_on;

  assign umap = uart_layout(cfg[5:3]);

  generate
    if (HAS_IDE) begin : g_ide
      assign ide_on = cfg[6];
    end else begin : g_no_ide
      assign ide_on = 1'b0;
    end
  endgenerate

  always_comb begin
    win_base[W_FDC]  = FDC_BASE;  win_mask[W_FDC]  = MASK8; win_en[W_FDC]  = cfg[0];
    win_base[W_IDEC] = IDE_CMD;   win_mask[W_IDEC] = MASK8; win_en[W_IDEC] = ide_on;
    win_base[W_IDEK] = IDE_CTL;   win_mask[W_IDEK] = MASK1; win_en[W_IDEK] = ide_on;
    win_base[W_UA]   = umap.a.base; win_mask[W_UA] = MASK8; win_en[W_UA]   = umap.a.en;
    win_base[W_UB]   = umap.b.base; win_mask[W_UB] = MASK8; win_en[W_UB]   = umap.b.en;
    win_en[W_LPT]   = 1'b1;
    win_mask[W_LPT] = MASK8;
    unique case (cfg[2:1])
      2'b01:   begin win_base[W_LPT] = LPT_MONO; win_mask[W_LPT] = MASK4; end
      2'b10:   win_base[W_LPT] = LPT_PRI;
      2'b11:   win_base[W_LPT] = LPT_SEC;
      default: begin win_base[W_LPT] = '0; win_en[W_LPT] = 1'b0; end
    endcase
  end

  assign lpt_irq_en = (cfg[2:1] != 2'b00);
  assign ua_irq4    = umap.a.en && umap.a.base[8];
  assign ub_irq4    = umap.b.en && umap.b.base[8];
endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
  import sio_cfg_pkg::*;
#(
  parameter bit               HAS_IDE = 1'b1,
  parameter logic [CFG_W-1:0] RST_VAL = 8'h9D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [CFG_W-1:0] io_wdata,
  input  logic             io_wr,
  input  logic             io_rd,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             cs_cfg,
  output logic             cs_fdc,
  output logic             cs_lpt,
  output logic             cs_uart_a,
  output logic             cs_uart_b,
  output logic             cs_ide,
  output logic             lpt_irq_en,
  output logic             uart_a_irq4,
  output logic             uart_b_irq4
);
  logic [CFG_W-1:0] cfg_q;
  logic             rst_sync_n;
  logic             cfg_wr;
  logic [IO_AW-1:0] win_base [NWIN];
  logic [IO_AW-1:0] win_mask [NWIN];
  logic             win_en   [NWIN];
  logic [NWIN-1:0]  hit;

  assign cs_cfg = (io_addr == CFG_PORT);
  assign cfg_wr = io_wr && cs_cfg;

  sio_cfg_reg #(.RST_VAL(RST_VAL)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr),
    .wdata      (io_wdata),
    .cfg_q      (cfg_q),
    .rst_sync_n (rst_sync_n)
  );

  sio_port_map #(.HAS_IDE(HAS_IDE)) u_map (
    .cfg        (cfg_q),
    .win_base   (win_base),
    .win_mask   (win_mask),
    .win_en     (win_en),
    .lpt_irq_en (lpt_irq_en),
    .ua_irq4    (uart_a_irq4),
    .ub_irq4    (uart_b_irq4)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    sio_win_match #(.AW(IO_AW)) u_match (
      .addr (io_addr),
      .base (win_base[w]),
      .mask (win_mask[w]),
      .en   (win_en[w]),
      .hit  (hit[w])
    );
  end

  // config port and IDE control port take precedence inside the floppy range
  assign cs_fdc    = hit[W_FDC] && !cs_cfg && !hit[W_IDEK];
  assign cs_lpt    = hit[W_LPT];
  assign cs_uart_a = hit[W_UA];
  assign cs_uart_b = hit[W_UB];
  assign cs_ide    = hit[W_IDEC] || hit[W_IDEK];
  assign cfg_rdata = (io_rd && cs_cfg) ? cfg_q : '0;

  // R1
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_wr && io_addr == CFG_PORT) |=> (cfg_q == $past(io_wdata)));
  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(io_wr && io_addr == CFG_PORT) |=> $stable(cfg_q));
  // R9
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({cs_cfg, cs_fdc, cs_lpt, cs_uart_a, cs_uart_b, cs_ide}));
  // R8
  cfg_not_fdc_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_addr == CFG_PORT) |-> (cs_cfg && !cs_fdc));
  // R4
  lpt_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_q[2:1] == 2'b00) |-> (!cs_lpt && !lpt_irq_en));
  // R7
  ide_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!HAS_IDE || !cfg_q[6]) |-> !cs_ide);
  // R3
  fdc_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_q[0] |-> !cs_fdc);
endmodule

// File: tb/sim_sio_cfg_decode.sv
module sim_sio_cfg_decode;
  localparam int  CLK_PERIOD = 10;
  localparam bit  HAS_IDE    = 1'b1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata;
  logic        io_wr, io_rd;
  logic [7:0]  cfg_rdata;
  logic        cs_cfg, cs_fdc, cs_lpt, cs_uart_a, cs_uart_b, cs_ide;
  logic        lpt_irq_en, uart_a_irq4, uart_b_irq4;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] cur;
  logic [15:0] probes [0:76];

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_decode #(.HAS_IDE(HAS_IDE), .RST_VAL(8'h9D)) u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .cfg_rdata(cfg_rdata),
    .cs_cfg(cs_cfg), .cs_fdc(cs_fdc), .cs_lpt(cs_lpt),
    .cs_uart_a(cs_uart_a), .cs_uart_b(cs_uart_b), .cs_ide(cs_ide),
    .lpt_irq_en(lpt_irq_en), .uart_a_irq4(uart_a_irq4), .uart_b_irq4(uart_b_irq4)
  );

  // serial layout model: {a_en, a_base, b_en, b_base}
  function automatic logic [33:0] ser_model(input logic [7:0] r);
    logic [15:0] ab, bb;
    logic ae, be;
    ae = 0; be = 0; ab = 0; bb = 0;
    case (r[5:3])
      3'd1: begin ae = 1; ab = 16'h3F8; end
      3'd2: begin be = 1; bb = 16'h2F8; end
      3'd3: begin ae = 1; ab = 16'h3F8; be = 1; bb = 16'h2F8; end
      3'd4: begin ae = 1; ab = 16'h3E8; be = 1; bb = 16'h2E8; end
      3'd6: begin be = 1; bb = 16'h3F8; end
      3'd7: begin ae = 1; ab = 16'h2F8; be = 1; bb = 16'h3F8; end
      default: ;
    endcase
    return {ae, ab, be, bb};
  endfunction

  function automatic logic in_rng(input logic [15:0] a, lo, hi);
    return (a >= lo) && (a <= hi);
  endfunction

  // {cfg, fdc, lpt, ua, ub, ide}
  function automatic logic [5:0] cs_model(input logic [7:0] r, input logic [15:0] a);
    logic c, f, l, ua, ub, i;
    logic [33:0] s;
    s  = ser_model(r);
    c  = (a == 16'h3F3);
    i  = HAS_IDE && r[6] && (in_rng(a, 16'h1F0, 16'h1F7) || a == 16'h3F6);
    f  = r[0] && in_rng(a, 16'h3F0, 16'h3F7) && !c && !(i && a == 16'h3F6);
    case (r[2:1])
      2'd1: l = in_rng(a, 16'h3BC, 16'h3BF);
      2'd2: l = in_rng(a, 16'h378, 16'h37F);
      2'd3: l = in_rng(a, 16'h278, 16'h27F);
      default: l = 0;
    endcase
    ua = s[33] && in_rng(a, s[32:17], s[32:17] + 16'd7);
    ub = s[16] && in_rng(a, s[15:0],  s[15:0]  + 16'd7);
    return {c, f, l, ua, ub, i};
  endfunction

  function automatic logic [2:0] irq_model(input logic [7:0] r);
    logic [33:0] s;
    s = ser_model(r);
    return {r[2:1] != 2'b00, s[33] && s[25], s[16] && s[8]};
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h (cfg=%h addr=%h)", req, what, act, exp, cur, io_addr);
    end
  endtask

  task automatic probe(input logic [15:0] a);
    logic [5:0] e, g;
    logic [2:0] ei, gi;
    io_addr = a; #1;
    e  = cs_model(cur, a);
    g  = {cs_cfg, cs_fdc, cs_lpt, cs_uart_a, cs_uart_b, cs_ide};
    ei = irq_model(cur);
    gi = {lpt_irq_en, uart_a_irq4, uart_b_irq4};
    chk("R8", "cs_cfg",    {7'b0, g[5]}, {7'b0, e[5]});
    chk("R3", "cs_fdc",    {7'b0, g[4]}, {7'b0, e[4]});
    chk("R4", "cs_lpt",    {7'b0, g[3]}, {7'b0, e[3]});
    chk("R5", "cs_uart_a", {7'b0, g[2]}, {7'b0, e[2]});
    chk("R5", "cs_uart_b", {7'b0, g[1]}, {7'b0, e[1]});
    chk("R7", "cs_ide",    {7'b0, g[0]}, {7'b0, e[0]});
    chk("R4", "lpt_irq_en", {7'b0, gi[2]}, {7'b0, ei[2]});
    chk("R6", "uart_irq4", {6'b0, gi[1:0]}, {6'b0, ei[1:0]});
    chk("R9", "cs count<=1", {7'b0, $countones(g) <= 1}, 8'h01);
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk);
    io_addr = 16'h3F3; io_wdata = v; io_wr = 1; io_rd = 1; #1;
    chk("R11", "readback before edge", cfg_rdata, cur);
    @(posedge clk); #1;
    chk("R11", "readback after edge", cfg_rdata, v);
    chk("R1", "readback", cfg_rdata, v);
    io_wr = 0; io_rd = 0;
    cur = v;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] bases [0:10];
    logic [5:0]  c0, c1;
    int k;
    void'($urandom(32'd4242));
    bases = '{16'h3F0, 16'h3F3, 16'h3F6, 16'h378, 16'h3BC, 16'h278,
              16'h3F8, 16'h2F8, 16'h3E8, 16'h2E8, 16'h1F0};
    k = 0;
    foreach (bases[b]) begin
      probes[k] = bases[b] - 16'd1; probes[k+1] = bases[b];
      probes[k+2] = bases[b] + 16'd1; probes[k+3] = bases[b] + 16'd3;
      probes[k+4] = bases[b] + 16'd4; probes[k+5] = bases[b] + 16'd7;
      probes[k+6] = bases[b] + 16'd8;
      k += 7;
    end

    rst_n = 0; io_addr = 0; io_wdata = 0; io_wr = 0; io_rd = 0;
    cur = 8'h9D;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2: reset state
    io_addr = 16'h3F3; io_rd = 1; #1;
    chk("R2", "reset value", cfg_rdata, 8'h9D);
    io_rd = 0; #1;
    chk("R1", "rdata idle", cfg_rdata, 8'h00);
    io_addr = 16'h3F0; #1; chk("R2", "fdc on", {7'b0, cs_fdc}, 8'h01);
    io_addr = 16'h37A; #1; chk("R2", "lpt 378", {7'b0, cs_lpt}, 8'h01);
    io_addr = 16'h3FF; #1; chk("R2", "uart a 3F8", {7'b0, cs_uart_a}, 8'h01);
    io_addr = 16'h2F8; #1; chk("R2", "uart b 2F8", {7'b0, cs_uart_b}, 8'h01);
    io_addr = 16'h1F0; #1; chk("R2", "ide off", {7'b0, cs_ide}, 8'h00);

    // sweep all register values over boundary addresses
    for (int v = 0; v < 256; v++) begin
      wr_cfg(v[7:0]);
      for (int p = 0; p < 77; p++) probe(probes[p]);
      probe({6'b0, 10'($urandom)});
    end

    // R10: bit 7 has no decode effect
    for (int v = 0; v < 128; v += 9) begin
      wr_cfg(v[7:0]);
      io_addr = 16'h3F8; #1; c0 = {cs_cfg, cs_fdc, cs_lpt, cs_uart_a, cs_uart_b, cs_ide};
      wr_cfg(v[7:0] | 8'h80);
      io_addr = 16'h3F8; #1; c1 = {cs_cfg, cs_fdc, cs_lpt, cs_uart_a, cs_uart_b, cs_ide};
      chk("R10", "bit7 effect", {2'b0, c1}, {2'b0, c0});
    end

    // writes elsewhere must not change the register (R1)
    wr_cfg(8'h5A);
    @(negedge clk); io_addr = 16'h3F2; io_wdata = 8'hFF; io_wr = 1;
    @(negedge clk); io_wr = 0; io_addr = 16'h3F3; io_rd = 1; #1;
    chk("R1", "write off-port ignored", cfg_rdata, 8'h5A);
    io_rd = 0;

    // random mix
    for (int n = 0; n < 300; n++) begin
      wr_cfg(8'($urandom));
      for (int j = 0; j < 6; j++) probe({6'b0, 10'($urandom)});
    end

    summary();
  end
endmodule